// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Arbiter

This block decides which of five interrupt sources is offered to the processor next. The sources are two external lines, two timer overflows and one serial port. Each source is gated by its own enable bit and by a global enable bit. Each source also takes a two-bit level from a pair of priority words: one carries the high bit of every source, the other carries the low bit. A handler that is running can only be interrupted by a request whose level is strictly above it. A level-3 handler cannot be interrupted at all.

Arbitration happens once per machine cycle, on a `tick` strobe. The result is registered. It stays on the request outputs, with the same source and level, until the processor acknowledges it. The acknowledge strobe pushes the granted level into a four-bit in-service mask. The return strobe pops the highest level out of that mask. The highest bit set in the mask is the level of the handler that is running now, and new requests must beat that level.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `irq_valid` is 0 and `active_levels` is 0000.
- R2: When `enable_reg[7]` (global enable) is 0, no request is granted, whatever the other enable bits are.
- R3: Source enables sit at `enable_reg` bits 0 to 4. The mapping is bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A cleared bit masks its source. Bits 5 and 6 have no effect.
- R4: The level of source i is {`prio_hi[i]`,`prio_lo[i]`}, from 0 (lowest) to 3 (highest). Among requests of different levels, the highest level is granted and reported on `irq_level`.
- R5: Within one level, the lowest index wins. The order is external 0 (0), timer 0 (1), external 1 (2), timer 1 (3), serial (4), and the winner is reported on `irq_src`.
- R6: When `active_levels` is nonzero, only a request with a level strictly above the highest bit set in it can be granted. When `active_levels` is zero, a request of any level can be granted.
- R7: While `active_levels[3]` is set, no new request is granted.
- R8: A new grant is formed only on a clock edge where `tick` is 1 and `irq_valid` is 0. Once `irq_valid` is 1, `irq_valid`, `irq_src` and `irq_level` hold until `ack`.
- R9: `ack` while `irq_valid` is 1 clears `irq_valid` on the next edge and sets bit `irq_level` of `active_levels`. `ack` while `irq_valid` is 0 changes nothing.
- R10: `reti` clears the highest set bit of `active_levels`. If `ack` comes in the same cycle, the clear is applied to the old mask first, and then the acknowledged bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe; arbitration is sampled here |
| req_in | input | 5 | Raw request lines, index = polling order |
| enable_reg | input | 8 | Global enable at bit 7, source enables at bits 4..0 |
| prio_lo | input | 5 | Low priority bit per source |
| prio_hi | input | 5 | High priority bit per source |
| ack | input | 1 | Processor takes the offered request |
| reti | input | 1 | Return from the running handler |
| irq_valid | output | 1 | A request is being offered |
| irq_src | output | 3 | Index of the offered source |
| irq_level | output | 2 | Level of the offered source |
| active_levels | output | 4 | In-service mask, one bit per level |

## Verification
The hardest state to reach is a nested stack: a low-level handler still in service while a level-3 handler sits above it. The lower bit must then survive a return while the upper bit is removed. The stimulus gets there by acknowledging a level-2 grant, raising one source to level 3, and acknowledging that grant as well. It then checks that the same requests produce no grant. Finally it returns once and acknowledges again in the same cycle as a return, to exercise the order of clear and set.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int SRC_W   = $clog2(NUM_SRC) < 1 ? 1 : $clog2(NUM_SRC);

  // index of the highest set bit in a level mask (0 when empty)
  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] m);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (m[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import irq_prio_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int LW = LVL_W
) (
  input  logic              [N-1:0] req,
  input  logic              [N-1:0] en_bits,
  input  logic                      glb_en,
  input  logic              [N-1:0] hi,
  input  logic              [N-1:0] lo,
  input  logic                      busy,
  input  logic             [LW-1:0] cur_lvl,
  output logic              [N-1:0] elig,
  output logic [N-1:0]     [LW-1:0] lvls
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic          pend;
    logic [LW-1:0] my_lvl;
    always_comb begin
      my_lvl  = {hi[g], lo[g]};
      pend    = req[g] & en_bits[g] & glb_en;
      lvls[g] = my_lvl;
      elig[g] = pend & (!busy || (my_lvl > cur_lvl));
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int LW = LVL_W,
  parameter int SW = SRC_W
) (
  input  logic          [N-1:0] elig,
  input  logic [N-1:0] [LW-1:0] lvls,
  output logic                  found,
  output logic         [SW-1:0] win_src,
  output logic         [LW-1:0] win_lvl
);
  // descending scan with >= keeps the lowest index among the highest level
  always_comb begin
    found   = 1'b0;
    win_src = '0;
    win_lvl = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || lvls[i] >= win_lvl)) begin
        found   = 1'b1;
        win_src = SW'(i);
        win_lvl = lvls[i];
      end
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
  import irq_prio_pkg::*;
#(
  parameter int L  = NUM_LVL,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic  [L-1:0] mask
);
  logic [L-1:0] popped;
  logic [L-1:0] nxt;

  always_comb begin
    popped = mask;
    if (pop) popped[top_level(mask)] = 1'b0;
    nxt = popped;
    if (push) nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= nxt;
  end

  // R10
  pop_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && mask != '0) |=> (mask == ($past(mask) & ~(L'(1) << top_level($past(mask))))));
  // R9
  push_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> mask[$past(push_lvl)]);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int N_LVL = NUM_LVL,
  parameter int EN_W  = 8,
  parameter int GLB_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [N_SRC-1:0]   req_in,
  input  logic [EN_W-1:0]    enable_reg,
  input  logic [N_SRC-1:0]   prio_lo,
  input  logic [N_SRC-1:0]   prio_hi,
  input  logic               ack,
  input  logic               reti,
  output logic               irq_valid,
  output logic [SRC_W-1:0]   irq_src,
  output logic [LVL_W-1:0]   irq_level,
  output logic [N_LVL-1:0]   active_levels
);
  localparam int LW = LVL_W;
  localparam int SW = SRC_W;

  logic                  busy;
  logic [LW-1:0]         cur_lvl;
  logic [N_SRC-1:0]      elig;
  logic [N_SRC-1:0][LW-1:0] lvls;
  logic                  found;
  logic [SW-1:0]         win_src;
  logic [LW-1:0]         win_lvl;
  logic                  take;

  assign busy    = |active_levels;
  assign cur_lvl = top_level(active_levels);
  assign take    = ack & irq_valid;

  irq_src_gate #(.N(N_SRC), .LW(LW)) u_gate (
    .req     (req_in),
    .en_bits (enable_reg[N_SRC-1:0]),
    .glb_en  (enable_reg[GLB_BIT]),
    .hi      (prio_hi),
    .lo      (prio_lo),
    .busy    (busy),
    .cur_lvl (cur_lvl),
    .elig    (elig),
    .lvls    (lvls)
  );

  irq_pick #(.N(N_SRC), .LW(LW), .SW(SW)) u_pick (
    .elig    (elig),
    .lvls    (lvls),
    .found   (found),
    .win_src (win_src),
    .win_lvl (win_lvl)
  );

  irq_isr_stack #(.L(N_LVL), .LW(LW)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (take),
    .push_lvl (irq_level),
    .pop      (reti),
    .mask     (active_levels)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_src   <= '0;
      irq_level <= '0;
    end else if (irq_valid) begin
      if (ack) irq_valid <= 1'b0;
    end else if (tick && found) begin
      irq_valid <= 1'b1;
      irq_src   <= win_src;
      irq_level <= win_lvl;
    end
  end

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_src) && $stable(irq_level)));
  // R8
  grant_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_valid && !tick) |=> !irq_valid);
  // R2
  global_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_valid && !enable_reg[GLB_BIT]) |=> !irq_valid);
  // R6
  strictly_higher_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> ($past(active_levels) == '0 ||
                          irq_level > top_level($past(active_levels))));
  // R7
  top_level_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (active_levels[N_LVL-1] && !irq_valid) |=> !irq_valid);
  // R9
  ack_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ack) |=> !irq_valid);
endmodule

// File: tb/tb_irq_prio_arb.sv
`timescale 1ns/1ps
module tb_irq_prio_arb;
  logic       clk = 0;
  logic       rst = 1;
  logic       tick = 0;
  logic [4:0] req_in = '0;
  logic [7:0] enable_reg = '0;
  logic [4:0] prio_lo = '0;
  logic [4:0] prio_hi = '0;
  logic       ack = 0;
  logic       reti = 0;
  logic       irq_valid;
  logic [2:0] irq_src;
  logic [1:0] irq_level;
  logic [3:0] active_levels;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_arb dut (
    .clk(clk), .rst(rst), .tick(tick), .req_in(req_in), .enable_reg(enable_reg),
    .prio_lo(prio_lo), .prio_hi(prio_hi), .ack(ack), .reti(reti),
    .irq_valid(irq_valid), .irq_src(irq_src), .irq_level(irq_level),
    .active_levels(active_levels)
  );

  typedef struct {
    bit         v;
    logic [2:0] src;
    logic [1:0] lvl;
    logic [3:0] mask;
    string      tag;
  } exp_t;

  exp_t sb[$];

  function automatic void push_exp(bit v, logic [2:0] s, logic [1:0] l, logic [3:0] m, string t);
    exp_t e;
    e.v = v; e.src = s; e.lvl = l; e.mask = m; e.tag = t;
    sb.push_back(e);
  endfunction

  // monitor: compares at the falling edge after the driver queued an item
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        n_chk++;
        bad = (irq_valid !== e.v) || (active_levels !== e.mask) ||
              (e.v && (irq_src !== e.src || irq_level !== e.lvl));
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got v=%0b src=%0d lvl=%0d mask=%b, exp v=%0b src=%0d lvl=%0d mask=%b",
                   e.tag, irq_valid, irq_src, irq_level, active_levels,
                   e.v, e.src, e.lvl, e.mask);
        end
      end
    end
  end

  // one edge with the given strobes, then queue the expected outcome
  task automatic step(bit t, bit a, bit r, bit v, logic [2:0] s, logic [1:0] l,
                      logic [3:0] m, string tag);
    @(negedge clk);
    tick = t; ack = a; reti = r;
    @(posedge clk);
    #1;
    tick = 0; ack = 0; reti = 0;
    push_exp(v, s, l, m, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    push_exp(0, 0, 0, 4'b0000, "R1");

    // R2: global enable off
    @(negedge clk);
    enable_reg = 8'h1F; req_in = 5'b11111;
    step(1, 0, 0, 0, 0, 0, 4'b0000, "R2");

    // R8: no tick, no grant
    enable_reg = 8'h9F;
    step(0, 0, 0, 0, 0, 0, 4'b0000, "R8");
    // R5: all level 0, index 0 wins
    step(1, 0, 0, 1, 0, 0, 4'b0000, "R5");
    step(1, 1, 0, 0, 0, 0, 4'b0001, "R9");
    step(0, 0, 1, 0, 0, 0, 4'b0000, "R10");
    // R9: ack without a request is ignored
    step(0, 1, 0, 0, 0, 0, 4'b0000, "R9");

    // R3: external 0 disabled -> timer 0
    enable_reg = 8'h9E;
    step(1, 0, 0, 1, 1, 0, 4'b0000, "R3");
    // R8: hold while requests change and ticks arrive
    req_in = 5'b10000;
    step(1, 0, 0, 1, 1, 0, 4'b0000, "R8");
    step(0, 1, 0, 0, 0, 0, 4'b0001, "R9");
    step(0, 0, 1, 0, 0, 0, 4'b0000, "R10");

    // R3: only reserved bits plus global set
    enable_reg = 8'hE0; req_in = 5'b11111;
    step(1, 0, 0, 0, 0, 0, 4'b0000, "R3");

    // R4: serial level 2, timer 1 level 1
    enable_reg = 8'h9F; prio_hi = 5'b10000; prio_lo = 5'b01000;
    step(1, 0, 0, 1, 4, 2, 4'b0000, "R4");
    step(0, 1, 0, 0, 0, 0, 4'b0100, "R9");
    // R6: nothing above level 2
    step(1, 0, 0, 0, 0, 0, 4'b0100, "R6");
    // external 0 raised to level 3 preempts
    prio_hi = 5'b10001; prio_lo = 5'b01001;
    step(1, 0, 0, 1, 0, 3, 4'b0100, "R6");
    step(0, 1, 0, 0, 0, 0, 4'b1100, "R9");
    // R7: level 3 in service blocks everything
    step(1, 0, 0, 0, 0, 0, 4'b1100, "R7");
    // R10: return clears only the top bit
    step(0, 0, 1, 0, 0, 0, 4'b0100, "R10");
    step(1, 0, 0, 1, 0, 3, 4'b0100, "R4");
    // R10: return and ack together
    step(0, 1, 1, 0, 0, 0, 4'b1000, "R10");
    step(0, 0, 1, 0, 0, 0, 4'b0000, "R10");

    // R5: tie at level 1 among 1,3,4
    prio_hi = 5'b00000; prio_lo = 5'b11010; req_in = 5'b11010;
    step(1, 0, 0, 1, 1, 1, 4'b0000, "R5");
    step(0, 1, 0, 0, 0, 0, 4'b0010, "R9");
    step(0, 0, 1, 0, 0, 0, 4'b0000, "R10");
    req_in = 5'b11000;
    step(1, 0, 0, 1, 3, 1, 4'b0000, "R5");
    step(0, 1, 0, 0, 0, 0, 4'b0010, "R9");
    step(0, 0, 1, 0, 0, 0, 4'b0000, "R10");

    // R6: empty mask admits level 0
    prio_lo = 5'b00000; req_in = 5'b00100;
    step(1, 0, 0, 1, 2, 0, 4'b0000, "R6");

    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule